// File: doc/BRIEF.md
# Constant off-time current chopper

This block regulates the peak current of one bridge by chopping at a fixed off time. A digital flag from an external sense comparator says that the sensed current has crossed its reference. A second input from the gate logic says that the low-side switch is conducting. When the block accepts a trip, it raises a chop request. The gate logic answers that request by moving the bridge into its recirculation phase. The request stays high for a programmed number of clock cycles and then drops, which returns the bridge to its on phase. The dead time that the gate logic inserts downstream adds to the effective off time.

Two windows, both counted from the start of each on phase, qualify a trip. The first is a blanking window. It hides the comparator flag so that the current spike at low-side turn-on cannot act as a trip. The second is a minimum on time, which keeps the bridge on for a guaranteed number of cycles before it can be chopped again. The off time, the blanking length and the minimum on time are all run-time configuration values given in clock cycles.

Top module: `const_off_chopper`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `chop_req` is 0.
- R2: A trip is valid in a cycle when all of these hold: `chop_req` is 0, `ls_on` is 1, `sense_over` is 1, the on age is at least `cfg_blank`, and the on age is at least `cfg_min_on`. After a valid trip, `chop_req` is 1 in the following cycle.
- R3: While the on age is below `cfg_blank`, `sense_over` has no effect, and `chop_req` stays 0 in the following cycle.
- R4: While the on age is below `cfg_min_on`, no trip is accepted, even when the blanking window has closed. A comparator flag that is still high once both windows have closed trips in the first cycle in which both are open.
- R5: Once raised, `chop_req` stays high for exactly `cfg_off` consecutive cycles, using the value sampled in the trip cycle. A `cfg_off` of 0 gives one cycle.
- R6: A comparator flag that arrives while `chop_req` is high neither extends nor restarts the off phase.
- R7: While `ls_on` is 0, no trip is accepted, whatever the level of `sense_over`.
- R8: The on age is 0 in the first cycle in which `ls_on` is 1 and `chop_req` is 0 after any cycle in which that pair did not hold. It then rises by one per cycle. At the all-ones value of its window width it saturates, so that a window whose limit equals that value stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_over | input | 1 | Comparator flag: sensed current above reference |
| ls_on | input | 1 | Gate logic reports the low-side switch conducting |
| cfg_blank | input | BLANK_W | Blanking length in cycles |
| cfg_min_on | input | MINON_W | Minimum on time in cycles |
| cfg_off | input | OFF_W | Off-phase length in cycles (0 acts as 1) |
| chop_req | output | 1 | Registered request to enter recirculation |

## Verification
Two pairs of events can land in the same cycle, and both pairs are driven on purpose. In the first, the off phase expires while the comparator is still high and both windows have zero length, so the trip must be accepted in the very first on cycle, at on age 0. In the second, the comparator flag is held high across the cycle in which the last window closes, and the request must rise exactly one cycle after that age is reached. A behavioural model judges both pairs cycle by cycle. The model keeps its own integer ages and off countdown and is compared against `chop_req` on every clock.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic {
    PH_ON  = 1'b0,
    PH_OFF = 1'b1
  } chop_phase_e;
endpackage

// File: rtl/chop_window.sv
// Saturating on-age counter with a programmable opening threshold.
module chop_window #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         open
);
  localparam logic [W-1:0] AGE_MAX = '1;
  localparam logic [W-1:0] AGE_ONE = W'(1);

  logic [W-1:0] age;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      age <= '0;
    end else if (age != AGE_MAX) begin
      age <= age + AGE_ONE;
    end
  end

  assign open = run && (age >= limit);
endmodule

// File: rtl/chop_trip_gate.sv
// Qualifies a comparator trip against phase, low-side state and both windows.
module chop_trip_gate (
  input  logic off_active,
  input  logic ls_on,
  input  logic sense_over,
  input  logic blank_open,
  input  logic minon_open,
  output logic fire
);
  always_comb begin
    fire = 1'b0;
    if (!off_active && ls_on && sense_over) begin
      fire = blank_open && minon_open;
    end
  end
endmodule

// File: rtl/chop_monostable.sv
// Non-retriggerable off-time timer; the length is latched at the trip.
module chop_monostable
  import chop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [W-1:0] period,
  output logic         active
);
  localparam logic [W-1:0] CNT_ONE = W'(1);

  chop_phase_e  phase;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_ON;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_ON: begin
          if (fire) begin
            phase <= PH_OFF;
            cnt   <= (period == '0) ? CNT_ONE : period;
          end
        end
        PH_OFF: begin
          if (cnt <= CNT_ONE) begin
            phase <= PH_ON;
            cnt   <= '0;
          end else begin
            cnt <= cnt - CNT_ONE;
          end
        end
        default: phase <= PH_ON;
      endcase
    end
  end

  assign active = (phase == PH_OFF);
endmodule

// File: rtl/const_off_chopper.sv
module const_off_chopper #(
  parameter int BLANK_W = 8,
  parameter int MINON_W = 8,
  parameter int OFF_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sense_over,
  input  logic               ls_on,
  input  logic [BLANK_W-1:0] cfg_blank,
  input  logic [MINON_W-1:0] cfg_min_on,
  input  logic [OFF_W-1:0]   cfg_off,
  output logic               chop_req
);
  logic on_run;
  logic blank_open;
  logic minon_open;
  logic fire;
  logic off_active;

  // The on age runs only while the low side conducts outside an off phase.
  assign on_run = ls_on && !off_active;

  chop_window #(.W(BLANK_W)) u_blank (
    .clk   (clk),
    .rst   (rst),
    .run   (on_run),
    .limit (cfg_blank),
    .open  (blank_open)
  );

  chop_window #(.W(MINON_W)) u_minon (
    .clk   (clk),
    .rst   (rst),
    .run   (on_run),
    .limit (cfg_min_on),
    .open  (minon_open)
  );

  chop_trip_gate u_gate (
    .off_active (off_active),
    .ls_on      (ls_on),
    .sense_over (sense_over),
    .blank_open (blank_open),
    .minon_open (minon_open),
    .fire       (fire)
  );

  chop_monostable #(.W(OFF_W)) u_mono (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .period (cfg_off),
    .active (off_active)
  );

  assign chop_req = off_active;
endmodule

// File: rtl/chop_checker.sv
module chop_checker #(
  parameter int OFF_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ls_on,
  input logic             sense_over,
  input logic             blank_open,
  input logic             minon_open,
  input logic [OFF_W-1:0] cfg_off,
  input logic             chop_req
);
  localparam logic [OFF_W-1:0] LEN_ONE = OFF_W'(1);

  logic [OFF_W-1:0] exp_len;
  logic [OFF_W:0]   hi_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_len <= LEN_ONE;
      hi_len  <= '0;
    end else begin
      if (!chop_req) exp_len <= (cfg_off == '0) ? LEN_ONE : cfg_off;
      hi_len <= chop_req ? hi_len + 1'b1 : '0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !chop_req);

  assert_trip_fires_R2: assert property (@(posedge clk) disable iff (rst)
    (!chop_req && ls_on && sense_over && blank_open && minon_open) |=> chop_req);

  assert_blank_masks_R3: assert property (@(posedge clk) disable iff (rst)
    (!chop_req && !blank_open) |=> !chop_req);

  assert_min_on_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!chop_req && !minon_open) |=> !chop_req);

  assert_off_length_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(chop_req) |-> (hi_len == {1'b0, exp_len}));

  assert_no_extend_R6: assert property (@(posedge clk) disable iff (rst)
    (chop_req && hi_len >= {1'b0, exp_len}) |=> !chop_req);

  assert_low_side_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!chop_req && !ls_on) |=> !chop_req);
endmodule

bind const_off_chopper chop_checker #(.OFF_W(OFF_W)) u_chop_checker (
  .clk        (clk),
  .rst        (rst),
  .ls_on      (ls_on),
  .sense_over (sense_over),
  .blank_open (blank_open),
  .minon_open (minon_open),
  .cfg_off    (cfg_off),
  .chop_req   (chop_req)
);

// File: tb/test_const_off_chopper.sv
module test_const_off_chopper;
  localparam int CLK_P   = 10;
  localparam int BLANK_W = 8;
  localparam int MINON_W = 8;
  localparam int OFF_W   = 16;
  localparam int MAX_B   = (1 << BLANK_W) - 1;
  localparam int MAX_M   = (1 << MINON_W) - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               sense_over = 1'b0;
  logic               ls_on = 1'b0;
  logic [BLANK_W-1:0] cfg_blank = '0;
  logic [MINON_W-1:0] cfg_min_on = '0;
  logic [OFF_W-1:0]   cfg_off = OFF_W'(1);
  logic               chop_req;

  int    n_run = 0;
  int    n_fail = 0;
  string tag = "R1";

  int m_chop = 0, m_off = 0, m_ab = 0, m_am = 0;
  int rises = 0;

  const_off_chopper #(.BLANK_W(BLANK_W), .MINON_W(MINON_W), .OFF_W(OFF_W))
    i_const_off_chopper (
      .clk(clk), .rst(rst), .sense_over(sense_over), .ls_on(ls_on),
      .cfg_blank(cfg_blank), .cfg_min_on(cfg_min_on), .cfg_off(cfg_off),
      .chop_req(chop_req));

  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference, advanced on each edge, compared shortly after it.
  always @(posedge clk) begin
    int nab, nam, run, fire, prev;
    prev = m_chop;
    if (rst) begin
      m_chop = 0; m_off = 0; m_ab = 0; m_am = 0;
    end else begin
      run  = (ls_on && m_chop == 0) ? 1 : 0;
      fire = (run == 1 && sense_over && m_ab >= int'(cfg_blank) &&
              m_am >= int'(cfg_min_on)) ? 1 : 0;
      nab  = (run == 1) ? ((m_ab < MAX_B) ? m_ab + 1 : m_ab) : 0;
      nam  = (run == 1) ? ((m_am < MAX_M) ? m_am + 1 : m_am) : 0;
      if (m_chop == 1) begin
        if (m_off <= 1) m_chop = 0;
        m_off = m_off - 1;
      end else if (fire == 1) begin
        m_chop = 1;
        m_off  = (cfg_off == '0) ? 1 : int'(cfg_off);
      end
      m_ab = nab; m_am = nam;
    end
    if (prev == 0 && m_chop == 1) rises++;
    #2;
    n_run++;
    if (int'(chop_req) != m_chop) begin
      n_fail++;
      $display("FAIL %s: chop_req=%0d expected %0d at %0t", tag, chop_req, m_chop, $time);
    end
  end

  task automatic drive(input int n, input bit ls, input bit se);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ls_on = ls;
      sense_over = se;
    end
  endtask

  task automatic setup(input int b, input int m, input int o);
    drive(3, 1'b0, 1'b0);
    @(negedge clk);
    cfg_blank = BLANK_W'(b);
    cfg_min_on = MINON_W'(m);
    cfg_off = OFF_W'(o);
  endtask

  task automatic expect_rises(input string t, input int exp);
    n_run++;
    if (rises != exp) begin
      n_fail++;
      $display("FAIL %s: off phases=%0d expected %0d", t, rises, exp);
    end
    rises = 0;
  endtask

  initial begin
    tag = "R1";
    drive(4, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b0; ls_on = 1'b0; sense_over = 1'b0;
    drive(2, 1'b0, 1'b0);
    rises = 0;

    tag = "R2"; setup(3, 5, 10);
    drive(8, 1'b1, 1'b0); drive(1, 1'b1, 1'b1); drive(20, 1'b1, 1'b0);
    expect_rises("R2", 1);

    tag = "R3"; setup(6, 2, 4);
    drive(10, 1'b1, 1'b1); drive(10, 1'b1, 1'b0);
    expect_rises("R3", 1);
    setup(6, 0, 4);
    drive(3, 1'b1, 1'b0); drive(3, 1'b1, 1'b1); drive(10, 1'b1, 1'b0);
    expect_rises("R3", 0);

    tag = "R4"; setup(2, 7, 4);
    drive(12, 1'b1, 1'b1); drive(10, 1'b1, 1'b0);
    expect_rises("R4", 1);

    tag = "R6"; setup(1, 1, 6);
    drive(40, 1'b1, 1'b1); drive(10, 1'b1, 1'b0);
    expect_rises("R6", 5);

    tag = "R7"; setup(0, 0, 3);
    drive(20, 1'b0, 1'b1);
    expect_rises("R7", 0);

    tag = "R5"; setup(0, 0, 0);
    drive(10, 1'b1, 1'b1); drive(5, 1'b1, 1'b0);
    expect_rises("R5", 5);
    setup(0, 0, 3);
    drive(12, 1'b1, 1'b1); drive(6, 1'b1, 1'b0);
    expect_rises("R5", 3);

    tag = "R8"; setup(3, 3, 5);
    drive(2, 1'b1, 1'b0); drive(1, 1'b0, 1'b1); drive(2, 1'b1, 1'b1);
    drive(6, 1'b1, 1'b1); drive(8, 1'b1, 1'b0);
    expect_rises("R8", 1);
    setup(200, MAX_M, 5);
    drive(270, 1'b1, 1'b1); drive(10, 1'b1, 1'b0);
    expect_rises("R8", 1);

    tag = "R1"; @(negedge clk); rst = 1'b1;
    drive(3, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b0;
    drive(2, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule